// File: doc/BRIEF.md
# Three-Register Operand Stack

This block is the evaluation stack of a small stack-oriented 32-bit processor. It holds three registers, A on top, then B, then C. A command interface loads values onto the stack, removes them, and runs binary operations whose operands are the top two entries. The result replaces them on top.

Each command is a single valid strobe with a 4-bit opcode and, for loads, a data word. Every operation except multiply completes at the clock edge that accepts it. Shifts use a logarithmic barrel network. Multiply is iterative: it accumulates one slice of the multiplier per cycle and raises `busy` until the product is written. The top of the stack is visible at all times on `top_a`. Nothing in the block detects stack overflow or underflow.

Top module: `opstack_core`

## Requirements
- R1: A synchronous active-high `rst` clears A, B and C to zero and drives `busy` low, including when it is asserted during a multiply.
- R2: Opcode 1 (push) loads `push_data` into A, moves the old A into B and the old B into C, all at the accepting edge.
- R3: Opcode 2 (pop) moves B into A and C into B at the accepting edge. C is left with an undefined value.
- R4: Opcode 3 (add) writes B+A into A, and opcode 4 (subtract) writes B-A into A. Both wrap modulo 2^32.
- R5: Opcodes 5, 6 and 7 write the bitwise AND, OR and XOR of B and A into A.
- R6: Opcode 8 (shift left) and opcode 9 (shift right) write B shifted logically by A[4:0] into A in one cycle, for amounts from 0 to 31. The upper bits of A are ignored.
- R7: Every binary operation, multiply included, moves C into B when it writes its result, and leaves C with an undefined value.
- R8: Opcode 10 (multiply) writes the low 32 bits of B times A into A. `busy` is high for exactly 3 cycles after the accepting edge, and the result appears on `top_a` when `busy` falls, 4 cycles after the command cycle.
- R9: Commands presented while `busy` is high are ignored and leave the stack unchanged.
- R10: With `cmd_valid` low, or with opcode 0 or an opcode from 11 to 15, the stack does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, accepted when `busy` is low |
| cmd_op | input | 4 | Operation code |
| push_data | input | 32 | Value loaded by a push |
| top_a | output | 32 | Current content of A |
| busy | output | 1 | High while a multiply is in progress |

## Verification
Every cycle, the assertions check the register movement of push, pop and binary operations, and that the stack holds while idle or busy. They also check that a multiply keeps `busy` high for exactly the required run and ends with the product on top. What the assertions cannot show is the arithmetic value of each single-cycle operation, the shift boundary amounts and the value wraparound. Those are covered by the bench's vector table. The bench's directed scenarios also show that a command offered during a multiply leaves no trace in the stack, and that a reset in the middle of a multiply clears everything.

// File: rtl/opstack_pkg.sv
`timescale 1ns/1ps
package opstack_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP  = 4'd0,
      OP_PUSH = 4'd1,
      OP_POP  = 4'd2,
      OP_ADD  = 4'd3,
      OP_SUB  = 4'd4,
      OP_AND  = 4'd5,
      OP_OR   = 4'd6,
      OP_XOR  = 4'd7,
      OP_SHL  = 4'd8,
      OP_SHR  = 4'd9,
      OP_MUL  = 4'd10
   } stk_op_e;

   // single-cycle two-operand operations that go through the ALU
   function automatic logic is_alu_op(input logic [OP_W-1:0] code);
      return (code >= 4'(OP_ADD)) && (code <= 4'(OP_SHR));
   endfunction

endpackage

// File: rtl/opstack_shifter.sv
`timescale 1ns/1ps
module opstack_shifter #(
   parameter int DATA_W  = 32,
   parameter bit STAGED  = 1'b1,
   localparam int AMT_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [AMT_W-1:0]  amt,
   input  logic              to_left,
   output logic [DATA_W-1:0] dout
);

   if (STAGED) begin : g_staged
      logic [DATA_W-1:0] stage [AMT_W+1];
      assign stage[0] = din;
      for (genvar i = 0; i < AMT_W; i++) begin : g_stage
         localparam int DIST = 1 << i;
         logic [DATA_W-1:0] moved;
         assign moved = to_left ? (stage[i] << DIST) : (stage[i] >> DIST);
         assign stage[i+1] = amt[i] ? moved : stage[i];
      end
      assign dout = stage[AMT_W];
   end else begin : g_flat
      assign dout = to_left ? (din << amt) : (din >> amt);
   end

endmodule

// File: rtl/opstack_alu.sv
`timescale 1ns/1ps
module opstack_alu
   import opstack_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  stk_op_e           op,
   input  logic [DATA_W-1:0] lhs,   // second entry (B)
   input  logic [DATA_W-1:0] rhs,   // top entry (A)
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] shifted;

   opstack_shifter #(
      .DATA_W (DATA_W),
      .STAGED (1'b1)
   ) shift_i (
      .din     (lhs),
      .amt     (rhs[AMT_W-1:0]),
      .to_left (op == OP_SHL),
      .dout    (shifted)
   );

   always_comb begin
      unique case (op)
         OP_ADD:          result = lhs + rhs;
         OP_SUB:          result = lhs - rhs;
         OP_AND:          result = lhs & rhs;
         OP_OR:           result = lhs | rhs;
         OP_XOR:          result = lhs ^ rhs;
         OP_SHL, OP_SHR:  result = shifted;
         default:         result = rhs;
      endcase
   end

endmodule

// File: rtl/opstack_mul.sv
`timescale 1ns/1ps
module opstack_mul #(
   parameter int DATA_W     = 32,
   parameter int MUL_CYCLES = 4,
   localparam int CHUNK_W   = DATA_W / MUL_CYCLES,
   localparam int CNT_W     = $clog2(MUL_CYCLES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [DATA_W-1:0] mcand_in,
   input  logic [DATA_W-1:0] mplier_in,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] product
);

   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(1);
   localparam logic [CNT_W-1:0] RUN_LEN   = CNT_W'(MUL_CYCLES - 1);

   logic [DATA_W-1:0] acc_q, mcand_q, mplier_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q;
   logic [DATA_W-1:0] step_sum;

   function automatic logic [DATA_W-1:0] slice_prod(
      input logic [DATA_W-1:0]  mc,
      input logic [CHUNK_W-1:0] sl
   );
      return mc * DATA_W'(sl);
   endfunction

   assign step_sum = acc_q + slice_prod(mcand_q, mplier_q[CHUNK_W-1:0]);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q    <= '0;
         mcand_q  <= '0;
         mplier_q <= '0;
         cnt_q    <= '0;
         busy_q   <= 1'b0;
      end else if (start && !busy_q) begin
         acc_q    <= slice_prod(mcand_in, mplier_in[CHUNK_W-1:0]);
         mcand_q  <= mcand_in << CHUNK_W;
         mplier_q <= mplier_in >> CHUNK_W;
         cnt_q    <= RUN_LEN;
         busy_q   <= 1'b1;
      end else if (busy_q) begin
         acc_q    <= step_sum;
         mcand_q  <= mcand_q << CHUNK_W;
         mplier_q <= mplier_q >> CHUNK_W;
         cnt_q    <= cnt_q - 1'b1;
         if (cnt_q == LAST_STEP) busy_q <= 1'b0;
      end
   end

   assign busy    = busy_q;
   assign done    = busy_q && (cnt_q == LAST_STEP);
   assign product = step_sum;

endmodule

// File: rtl/opstack_core.sv
`timescale 1ns/1ps
module opstack_core
   import opstack_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int MUL_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  logic [OP_W-1:0]   cmd_op,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] top_a,
   output logic              busy
);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("opstack_core: DATA_W must be a power of two");
   end
   if (MUL_CYCLES < 2 || (DATA_W % MUL_CYCLES) != 0) begin : g_bad_mul
      $error("opstack_core: MUL_CYCLES must be >= 2 and divide DATA_W");
   end

   logic [DATA_W-1:0] reg_a, reg_b, reg_c;
   stk_op_e           cmd_kind;
   logic              take;
   logic [DATA_W-1:0] alu_res, mul_prod;
   logic              mul_busy, mul_done;

   assign cmd_kind = stk_op_e'(cmd_op);
   assign take     = cmd_valid && !mul_busy;

   opstack_alu #(
      .DATA_W (DATA_W)
   ) alu_i (
      .op     (cmd_kind),
      .lhs    (reg_b),
      .rhs    (reg_a),
      .result (alu_res)
   );

   opstack_mul #(
      .DATA_W     (DATA_W),
      .MUL_CYCLES (MUL_CYCLES)
   ) mul_i (
      .clk       (clk),
      .rst       (rst),
      .start     (take && cmd_kind == OP_MUL),
      .mcand_in  (reg_a),
      .mplier_in (reg_b),
      .busy      (mul_busy),
      .done      (mul_done),
      .product   (mul_prod)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         reg_a <= '0;
         reg_b <= '0;
         reg_c <= '0;
      end else if (mul_done) begin
         reg_a <= mul_prod;
         reg_b <= reg_c;
      end else if (take) begin
         if (cmd_kind == OP_PUSH) begin
            reg_a <= push_data;
            reg_b <= reg_a;
            reg_c <= reg_b;
         end else if (cmd_kind == OP_POP) begin
            reg_a <= reg_b;
            reg_b <= reg_c;
         end else if (is_alu_op(cmd_op)) begin
            reg_a <= alu_res;
            reg_b <= reg_c;
         end
      end
   end

   assign top_a = reg_a;
   assign busy  = mul_busy;

endmodule

// File: rtl/opstack_core_chk.sv
`timescale 1ns/1ps
module opstack_core_chk
   import opstack_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int MUL_CYCLES = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_valid,
   input logic [OP_W-1:0]   cmd_op,
   input logic [DATA_W-1:0] push_data,
   input logic [DATA_W-1:0] top_a,
   input logic              busy,
   input logic [DATA_W-1:0] reg_b,
   input logic [DATA_W-1:0] reg_c
);

   logic              take, rst_d;
   logic [DATA_W-1:0] mul_ref;
   int unsigned       busy_run;

   assign take = cmd_valid && !busy;

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst) begin
         busy_run <= 0;
         mul_ref  <= '0;
      end else begin
         busy_run <= busy ? busy_run + 1 : 0;
         if (take && cmd_op == 4'(OP_MUL)) mul_ref <= top_a * reg_b;
      end
   end

   always @(negedge clk) begin
      if (rst_d === 1'b1) begin
         AST_RESET_CLEAR: assert (top_a == '0 && reg_b == '0 && reg_c == '0 && !busy); // R1
      end
   end

   AST_PUSH_LOAD: assert property (@(posedge clk) disable iff (rst)
      take && cmd_op == 4'(OP_PUSH) |=> top_a == $past(push_data) && reg_b == $past(top_a) && reg_c == $past(reg_b)); // R2

   AST_POP_SHIFT: assert property (@(posedge clk) disable iff (rst)
      take && cmd_op == 4'(OP_POP) |=> top_a == $past(reg_b) && reg_b == $past(reg_c)); // R3

   AST_BINOP_C_TO_B: assert property (@(posedge clk) disable iff (rst)
      take && is_alu_op(cmd_op) |=> reg_b == $past(reg_c)); // R7

   AST_MUL_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
      take && cmd_op == 4'(OP_MUL) |=> busy); // R8

   AST_MUL_RUN_LEN: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> busy_run == MUL_CYCLES - 1); // R8

   AST_MUL_RESULT: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> top_a == mul_ref); // R8

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(reg_c)); // R9

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !busy && !cmd_valid |=> $stable(top_a) && $stable(reg_b) && $stable(reg_c)); // R10

endmodule

bind opstack_core opstack_core_chk #(
   .DATA_W     (DATA_W),
   .MUL_CYCLES (MUL_CYCLES)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .push_data (push_data),
   .top_a     (top_a),
   .busy      (busy),
   .reg_b     (reg_b),
   .reg_c     (reg_c)
);

// File: tb/opstack_core_tb_top.sv
`timescale 1ns/1ps
module opstack_core_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = 4'd0;
   logic [31:0] push_data = '0;
   logic [31:0] top_a;
   logic        busy;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   opstack_core dut_i (
      .clk       (clk),
      .rst       (rst),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .push_data (push_data),
      .top_a     (top_a),
      .busy      (busy)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NVEC = 38;
   localparam vec_t VECS [NVEC] = '{
      '{4'd2,  32'h0,         32'h0,         8'd1},  // R1 pop after reset: B was cleared
      '{4'd2,  32'h0,         32'h0,         8'd1},  // R1 pop again: C was cleared
      '{4'd1,  32'h5,         32'h5,         8'd2},  // R2
      '{4'd1,  32'h7,         32'h7,         8'd2},  // R2
      '{4'd1,  32'h9,         32'h9,         8'd2},  // R2
      '{4'd3,  32'h0,         32'h10,        8'd4},  // R4 7+9
      '{4'd4,  32'h0,         32'hFFFF_FFF5, 8'd4},  // R4 5-16 wraps
      '{4'd1,  32'hF0F0_00FF, 32'hF0F0_00FF, 8'd2},  // R2
      '{4'd5,  32'h0,         32'hF0F0_00F5, 8'd5},  // R5 and
      '{4'd1,  32'h0F0F_0F0F, 32'h0F0F_0F0F, 8'd2},  // R2
      '{4'd6,  32'h0,         32'hFFFF_0FFF, 8'd5},  // R5 or
      '{4'd1,  32'h0000_FFFF, 32'h0000_FFFF, 8'd2},  // R2
      '{4'd7,  32'h0,         32'hFFFF_F000, 8'd5},  // R5 xor
      '{4'd1,  32'h8000_0001, 32'h8000_0001, 8'd2},  // R2
      '{4'd1,  32'h4,         32'h4,         8'd2},  // R2
      '{4'd8,  32'h0,         32'h0000_0010, 8'd6},  // R6 left by 4, top bit lost
      '{4'd1,  32'h8000_0000, 32'h8000_0000, 8'd2},  // R2
      '{4'd1,  32'h3F,        32'h3F,        8'd2},  // R2
      '{4'd9,  32'h0,         32'h1,         8'd6},  // R6 right by 31, bit 5 ignored
      '{4'd1,  32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'd2},  // R2
      '{4'd1,  32'h20,        32'h20,        8'd2},  // R2
      '{4'd8,  32'h0,         32'hDEAD_BEEF, 8'd6},  // R6 amount 0
      '{4'd1,  32'h1,         32'h1,         8'd2},  // R2
      '{4'd1,  32'h2,         32'h2,         8'd2},  // R2
      '{4'd1,  32'h3,         32'h3,         8'd2},  // R2
      '{4'd2,  32'h0,         32'h2,         8'd3},  // R3
      '{4'd2,  32'h0,         32'h1,         8'd3},  // R3 old C came up through B
      '{4'd1,  32'h11,        32'h11,        8'd2},  // R2
      '{4'd1,  32'h22,        32'h22,        8'd2},  // R2
      '{4'd1,  32'h33,        32'h33,        8'd2},  // R2
      '{4'd7,  32'h0,         32'h11,        8'd5},  // R5 22^33
      '{4'd2,  32'h0,         32'h11,        8'd7},  // R7 B now holds old C
      '{4'd0,  32'hAAAA_AAAA, 32'h11,        8'd10}, // R10 nop
      '{4'd15, 32'hAAAA_AAAA, 32'h11,        8'd10}, // R10 unassigned
      '{4'd11, 32'hAAAA_AAAA, 32'h11,        8'd10}, // R10 unassigned
      '{4'd1,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd2},  // R2
      '{4'd1,  32'h2,         32'h2,         8'd2},  // R2
      '{4'd3,  32'h0,         32'h1,         8'd4}   // R4 add wraps
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] op, input logic [31:0] d);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      push_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // issues a multiply, offers a push during busy, returns busy length
   task automatic run_mul(input logic [31:0] before_top, output int run);
      issue(4'd10, 32'h0);
      run = 0;
      while (busy && run < 20) begin
         run++;
         if (run == 1) begin
            check("R9 top held while busy", top_a, before_top);
            cmd_valid = 1'b1;
            cmd_op    = 4'd1;
            push_data = 32'h5555_5555;
         end else begin
            cmd_valid = 1'b0;
         end
         @(negedge clk);
      end
      cmd_valid = 1'b0;
   endtask

   initial begin : main
      logic [63:0] full;
      int          run;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R1 reset top", top_a, 32'h0);
      check("R1 reset busy", 32'(busy), 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         issue(VECS[i].op, VECS[i].data);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), top_a, VECS[i].exp);
      end

      // R10: data offered without the strobe
      @(negedge clk);
      cmd_op = 4'd1; push_data = 32'h7777_7777; cmd_valid = 1'b0;
      @(negedge clk);
      check("R10 strobe low", top_a, 32'h1);

      // R8 multiply with R9 ignored push and R7 C into B
      issue(4'd1, 32'h0000_CAFE);
      issue(4'd1, 32'h1234_5678);
      issue(4'd1, 32'h9ABC_DEF0);
      full = 64'h1234_5678 * 64'h9ABC_DEF0;
      run_mul(32'h9ABC_DEF0, run);
      check("R8 busy length", 32'(run), 32'd3);
      check("R8 product", top_a, full[31:0]);
      check("R8 busy low after", 32'(busy), 32'h0);
      issue(4'd2, 32'h0);
      check("R9 R7 pop after multiply", top_a, 32'h0000_CAFE);

      issue(4'd1, 32'hFFFF_FFFF);
      issue(4'd1, 32'hFFFF_FFFF);
      run_mul(32'hFFFF_FFFF, run);
      check("R8 busy length max operands", 32'(run), 32'd3);
      check("R8 product max operands", top_a, 32'h1);

      // R1: reset during a multiply
      issue(4'd1, 32'h3);
      issue(4'd1, 32'h4);
      issue(4'd10, 32'h0);
      check("R8 busy after start", 32'(busy), 32'h1);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      check("R1 top after mid reset", top_a, 32'h0);
      check("R1 busy after mid reset", 32'(busy), 32'h0);
      issue(4'd2, 32'h0);
      check("R1 B cleared by mid reset", top_a, 32'h0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule